// File: doc/BRIEF.md
# Bit Error Counter with Serial Readout

This block measures the error rate of a serial link. Each clock cycle on which the valid strobe is high, it compares one received bit with the bit that was expected. It counts every compared bit, and separately every bit that did not match. Both counters stop at their all-ones value instead of wrapping. The error counter also has a sticky overflow flag. A synchronous clear sets all three back to zero.

An external host reads the results over three wires: an active-low select, a shift clock and a data output. Both host inputs pass through two-flop synchronizers into the local clock domain. When select falls, the overflow flag and both counts are copied together into one shift register. After that, each rising edge of the host clock moves the register one bit toward the data pin. The counters keep running while the host reads, and the copy stays fixed, so every field in a frame belongs to the same instant. The host divides the error count by the bit count to get the error rate.

Top module: `bit_err_meter`

## Requirements
- R1: The bit counter increases by one on each clock edge where `vld` is high. Cycles with `vld` low leave it unchanged.
- R2: The error counter increases by one on each edge where `vld` is high and `rx_bit` differs from `ref_bit`. A mismatch while `vld` is low has no effect.
- R3: The error counter stops at 2^ERR_W-1. An extra strobed mismatch at that value sets the overflow flag. Reaching the maximum without an extra mismatch leaves the flag clear. Once set, the flag stays set until `clr`.
- R4: The bit counter stops at 2^BIT_W-1 and has no flag.
- R5: `clr` high at a clock edge zeroes both counters and the flag. It takes priority over a strobe in the same cycle.
- R6: After reset, both counters, the flag and the shift register are zero, and `host_sdo` is low.
- R7: The frame is captured on the third clock edge that samples `host_sel` low. It holds every strobe up to and including the second such edge, and no later strobe. After capture, `host_sdo` shows the frame's first bit.
- R8: The frame is 1+ERR_W+BIT_W bits long. It is sent in this order: overflow flag, error count MSB first, bit count MSB first.
- R9: The frame advances one bit on the third clock edge that samples `host_sck` high, but only while `host_sel` is low. Edges of `host_sck` while `host_sel` is high are ignored. Zeros follow the last frame bit.
- R10: The counters keep counting during a readout. `host_sdo` changes only on a capture or a shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and flag |
| vld | input | 1 | Compare strobe |
| rx_bit | input | 1 | Received bit |
| ref_bit | input | 1 | Expected bit |
| host_sel | input | 1 | Host select, active low, asynchronous |
| host_sck | input | 1 | Host shift clock, asynchronous |
| host_sdo | output | 1 | Serial frame data to host |

## Verification
The bench uses narrow counters so that both saturation points can be reached. It checks the exact boundary where the error count reaches its maximum with the flag still clear, then adds one more mismatch to set the flag. A design that set the flag one error early, or wrapped the count to zero, would show a wrong flag bit or a small error field. Traffic runs during a readout, and the captured frame must match a snapshot taken at the predicted edge. A design that captured a cycle early or late, or copied the fields at different times, would return mismatched counts. Clock pulses with select high, a clear in the same cycle as a mismatch, and shifts past the end of the frame cover the cases where a stray shift, a lost clear or shifting in ones would show up on the data pin.

// File: rtl/ber_pkg.sv
package ber_pkg;
  // Action requested of the readout shift register in a cycle.
  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_LOAD  = 2'd1,
    SH_SHIFT = 2'd2
  } sh_act_t;

  function automatic int frame_bits(input int err_w, input int bit_w);
    return 1 + err_w + bit_w;
  endfunction
endpackage

// File: rtl/ber_rst_sync.sv
module ber_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= 1'b0;
      st2_q <= 1'b0;
    end else begin
      st1_q <= 1'b1;
      st2_q <= st1_q;
    end
  end

  assign rst_sync_n = st2_q;
endmodule

// File: rtl/ber_sync2.sv
module ber_sync2 #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/ber_edge_ctl.sv
module ber_edge_ctl
  import ber_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sel_s,
  input  logic    sck_s,
  output sh_act_t act
);
  logic sel_d_q, sck_d_q;
  logic sel_fall, sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d_q <= 1'b1;
      sck_d_q <= 1'b0;
    end else begin
      sel_d_q <= sel_s;
      sck_d_q <= sck_s;
    end
  end

  always_comb begin
    sel_fall = sel_d_q & ~sel_s;
    sck_rise = sck_s & ~sck_d_q & ~sel_s;
    if (sel_fall)      act = SH_LOAD;
    else if (sck_rise) act = SH_SHIFT;
    else               act = SH_IDLE;
  end
endmodule

// File: rtl/ber_sat_cnt.sv
module ber_sat_cnt #(
  parameter int W      = 8,
  parameter bit STICKY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         sat_flag
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_max, cnt_en;

  assign at_max = (cnt_q == MAXV);
  assign cnt_en = clr | (inc & ~at_max);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  generate
    if (STICKY) begin : g_flag
      logic flag_q, flag_d, flag_en;
      always_comb begin
        flag_en = clr | (inc & at_max);
        flag_d  = ~clr;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (flag_en) flag_q <= flag_d;
      end
      assign sat_flag = flag_q;
    end else begin : g_noflag
      assign sat_flag = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ber_shifter.sv
module ber_shifter
  import ber_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sh_act_t       act,
  input  logic [FW-1:0] load_data,
  output logic          sdo
);
  logic [FW-1:0] sh_q, sh_d;
  logic          sh_en;

  always_comb begin
    sh_en = (act != SH_IDLE);
    if (act == SH_LOAD) sh_d = load_data;
    else                sh_d = {sh_q[FW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign sdo = sh_q[FW-1];
endmodule

// File: rtl/bit_err_meter.sv
module bit_err_meter
  import ber_pkg::*;
#(
  parameter int ERR_W = 24,
  parameter int BIT_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic rx_bit,
  input  logic ref_bit,
  input  logic host_sel,
  input  logic host_sck,
  output logic host_sdo
);
  localparam int FRAME_W = frame_bits(ERR_W, BIT_W);

  logic             rst_sync_n;
  logic [1:0]       host_s;
  sh_act_t          sh_act;
  logic             hit;
  logic [ERR_W-1:0] err_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic             err_ovf;
  logic             bit_flag_unused;

  ber_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ber_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async ({host_sel, host_sck}),
    .d_sync  (host_s)
  );

  ber_edge_ctl u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .sel_s (host_s[1]),
    .sck_s (host_s[0]),
    .act   (sh_act)
  );

  assign hit = vld & (rx_bit ^ ref_bit);

  ber_sat_cnt #(.W(ERR_W), .STICKY(1'b1)) u_err (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (clr),
    .inc      (hit),
    .cnt      (err_cnt),
    .sat_flag (err_ovf)
  );

  ber_sat_cnt #(.W(BIT_W), .STICKY(1'b0)) u_bits (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (clr),
    .inc      (vld),
    .cnt      (bit_cnt),
    .sat_flag (bit_flag_unused)
  );

  ber_shifter #(.FW(FRAME_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .act       (sh_act),
    .load_data ({err_ovf, err_cnt, bit_cnt}),
    .sdo       (host_sdo)
  );
endmodule

// File: rtl/ber_meter_chk.sv
module ber_meter_chk
  import ber_pkg::*;
#(
  parameter int ERR_W = 24,
  parameter int BIT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic [ERR_W-1:0] err_cnt,
  input logic [BIT_W-1:0] bit_cnt,
  input logic             ovf,
  input sh_act_t          act,
  input logic             sdo
);
  localparam logic [ERR_W-1:0] EMAX = '1;
  localparam logic [BIT_W-1:0] BMAX = '1;

  assert_err_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);

  assert_ovf_at_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (err_cnt == EMAX));

  assert_bit_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == BMAX && !clr) |=> (bit_cnt == BMAX));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_cnt == '0 && bit_cnt == '0 && !ovf));

  assert_sdo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act == SH_IDLE) |=> $stable(sdo));

  generate
    if (ERR_W <= BIT_W) begin : g_order
      assert_err_le_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ({{(BIT_W-ERR_W){1'b0}}, err_cnt} <= bit_cnt));
    end
  endgenerate
endmodule

bind bit_err_meter ber_meter_chk #(.ERR_W(ERR_W), .BIT_W(BIT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .clr     (clr),
  .err_cnt (err_cnt),
  .bit_cnt (bit_cnt),
  .ovf     (err_ovf),
  .act     (sh_act),
  .sdo     (host_sdo)
);

// File: tb/bit_err_meter_test.sv
module bit_err_meter_test;
  localparam int ERR_W = 4;
  localparam int BIT_W = 6;
  localparam int FW    = 1 + ERR_W + BIT_W;
  localparam int EMAX  = (1 << ERR_W) - 1;
  localparam int BMAX  = (1 << BIT_W) - 1;

  logic clk, rst_n, clr, vld, rx_bit, ref_bit, host_sel, host_sck;
  logic host_sdo;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  bit_err_meter #(.ERR_W(ERR_W), .BIT_W(BIT_W)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .vld(vld), .rx_bit(rx_bit),
    .ref_bit(ref_bit), .host_sel(host_sel), .host_sck(host_sck),
    .host_sdo(host_sdo)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference model, stepped on every rising edge.
  int m_err, m_bits, m_ovf, rcnt, lo_cnt, hi_cnt;
  logic [FW-1:0] m_sh, cap_val;

  function automatic logic [FW-1:0] mk(input int o, input int e, input int b);
    logic [31:0] ev, bv;
    ev = e; bv = b;
    return {o[0], ev[ERR_W-1:0], bv[BIT_W-1:0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) rcnt = 0;
    else if (rcnt < 3) rcnt++;
    if (rcnt < 3) begin
      m_err = 0; m_bits = 0; m_ovf = 0; lo_cnt = 0; hi_cnt = 0; m_sh = '0;
    end else begin
      lo_cnt = host_sel ? 0 : (lo_cnt < 1000 ? lo_cnt + 1 : lo_cnt);
      hi_cnt = host_sck ? (hi_cnt < 1000 ? hi_cnt + 1 : hi_cnt) : 0;
      if (lo_cnt == 3) begin
        m_sh = mk(m_ovf, m_err, m_bits);
        cap_val = m_sh;
      end else if (hi_cnt == 3 && lo_cnt >= 3) begin
        m_sh = m_sh << 1;
      end
      if (clr) begin
        m_err = 0; m_bits = 0; m_ovf = 0;
      end else if (vld) begin
        if (m_bits < BMAX) m_bits++;
        if (rx_bit != ref_bit) begin
          if (m_err == EMAX) m_ovf = 1;
          else m_err++;
        end
      end
    end
  end

  // Per-clock comparison of the serial output with the model (R9, R7).
  always @(negedge clk) begin
    if (rst_n && rcnt >= 3 && !finished) begin
      n_chk++;
      if (host_sdo !== m_sh[FW-1]) begin
        n_fail++;
        $display("FAIL R9 per-clock host_sdo actual=%0b expected=%0b", host_sdo, m_sh[FW-1]);
      end
    end
  end

  task automatic check(input string tag, input logic [FW-1:0] act_v, input logic [FW-1:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic strobe(input int n, input int nerr, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b1;
      ref_bit = i[0];
      rx_bit  = (i < nerr) ? ~i[0] : i[0];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        vld = 1'b0; rx_bit = 1'b1; ref_bit = 1'b0;
      end
    end
    @(negedge clk);
    vld = 1'b0; rx_bit = 1'b0; ref_bit = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic read_frame(output logic [FW-1:0] f);
    @(negedge clk); host_sel = 1'b0;
    repeat (4) @(negedge clk);
    f[FW-1] = host_sdo;
    for (int i = FW - 2; i >= 0; i--) begin
      host_sck = 1'b1; repeat (4) @(negedge clk);
      host_sck = 1'b0; repeat (4) @(negedge clk);
      f[i] = host_sdo;
    end
    host_sel = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [FW-1:0] f;
    logic          held;
    rst_n = 1'b0; clr = 1'b0; vld = 1'b0; rx_bit = 1'b0; ref_bit = 1'b0;
    host_sel = 1'b1; host_sck = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R6: reset state
    check("R6 sdo after reset", {{(FW-1){1'b0}}, host_sdo}, '0);
    read_frame(f);
    check("R6 frame after reset", f, mk(0, 0, 0));

    // R1 R2 R8: counts with unstrobed mismatches between strobes
    strobe(10, 3, 1);
    read_frame(f);
    check("R1 R2 R8 ten strobes three errors", f, mk(0, 3, 10));

    // R9: host clock edges with select high are ignored
    held = host_sdo;
    for (int k = 0; k < 3; k++) begin
      host_sck = 1'b1; repeat (6) @(negedge clk);
      host_sck = 1'b0; repeat (6) @(negedge clk);
    end
    check("R9 sck ignored while deselected", {{(FW-1){1'b0}}, host_sdo}, {{(FW-1){1'b0}}, held});

    // R5: clear
    pulse_clr();
    read_frame(f);
    check("R5 clear zeroes", f, mk(0, 0, 0));

    // R3: exactly at maximum, flag still clear
    strobe(EMAX, EMAX, 0);
    read_frame(f);
    check("R3 at max no overflow", f, mk(0, EMAX, EMAX));

    // R3: one more mismatch sets flag
    strobe(1, 1, 0);
    read_frame(f);
    check("R3 overflow set", f, mk(1, EMAX, EMAX + 1));

    // R3: flag sticky through matching traffic
    strobe(5, 0, 0);
    read_frame(f);
    check("R3 overflow sticky", f, mk(1, EMAX, EMAX + 6));

    // R4: bit counter saturates
    strobe(60, 0, 0);
    read_frame(f);
    check("R4 bit counter saturates", f, mk(1, EMAX, BMAX));

    // R5: clear wins over a strobed mismatch in the same cycle
    @(negedge clk); clr = 1'b1; vld = 1'b1; rx_bit = 1'b1; ref_bit = 1'b0;
    @(negedge clk); clr = 1'b0; vld = 1'b0; rx_bit = 1'b0;
    read_frame(f);
    check("R5 clear priority over strobe", f, mk(0, 0, 0));

    // R7 R10: capture during continuous traffic
    fork
      strobe(24, 8, 0);
      begin
        repeat (6) @(negedge clk);
        read_frame(f);
      end
    join
    check("R7 snapshot at predicted edge", f, cap_val);
    n_chk++;
    if (f == mk(0, 0, 0) || f == mk(0, 8, 24)) begin
      n_fail++;
      $display("FAIL R7 snapshot not mid-traffic actual=%h expected=partial", f);
    end
    read_frame(f);
    check("R10 counting continued during readout", f, mk(0, 8, 24));

    // R9: zeros follow the last frame bit
    @(negedge clk); host_sel = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < FW + 1; i++) begin
      host_sck = 1'b1; repeat (4) @(negedge clk);
      host_sck = 1'b0; repeat (4) @(negedge clk);
    end
    check("R9 zero fill after frame", {{(FW-1){1'b0}}, host_sdo}, '0);
    host_sel = 1'b1;
    repeat (6) @(negedge clk);

    finish_run();
  end
endmodule